// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Replacement Selector

This block tracks recency for an 8-way set-associative cache with a binary decision tree of seven bits per set, and names the way to replace when a miss needs a line. The tag store, data store and refill path live elsewhere. The surrounding cache presents a set index together with that set's valid mask. It reads back a victim way and a flag that tells whether that way was simply empty. Whenever a way is used, the cache reports it with a strobe.

Victim choice is combinational from the addressed set's current tree bits. An empty way always wins over the tree. A reported access rewrites only the three tree bits on that way's path, so that the tree steers away from it. The write lands at the next clock edge. A synchronous clear, or reset, zeroes the tree of every set at once.

Top module: `plru8_tree`

## Requirements
- R1: After reset, every set's tree is zero, so with all eight ways valid the victim of every set is way 0 with victim_invalid low.
- R2: When valid_mask (bit i = way i holds a line) is not all ones, victim_way is the lowest-numbered way whose valid bit is 0 and victim_invalid is 1.
- R3: When valid_mask is all ones, victim_invalid is 0 and the tree decides the victim. Node n0 = 1 selects ways 4-7, then n2 = 1 selects 6/7 (n6 = 1 picks 7) and n2 = 0 selects 4/5 (n5 = 1 picks 5). Node n0 = 0 selects ways 0-3, then n1 = 1 selects 2/3 (n4 = 1 picks 3) and n1 = 0 selects 0/1 (n3 = 1 picks 1).
- R4: An access to way w changes only three bits. For ways 0/1 these are n0, n1 and n3, with n0 = 1, n1 = 1 and n3 = 1 for way 0, 0 for way 1. For ways 2/3 they are n0, n1 and n4, with n0 = 1, n1 = 0 and n4 = 1 for way 2, 0 for way 3. For ways 4/5 they are n0, n2 and n5, with n0 = 0, n2 = 1 and n5 = 1 for way 4, 0 for way 5. For ways 6/7 they are n0, n2 and n6, with n0 = 0, n2 = 0 and n6 = 1 for way 6, 0 for way 7.
- R5: An access changes only the tree of the set on set_idx; all other sets keep their state.
- R6: The tree update takes effect at the clock edge that samples touch_en. In the cycle of the strobe the victim still reflects the old tree, and without a strobe or clear the state is unchanged.
- R7: clr_all zeroes the tree of every set at the next edge, and wins over a simultaneous access.
- R8: Right after an access to way w of a set with all ways valid, the victim for that set is not w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all trees |
| clr_all | input | 1 | Synchronous clear of all trees |
| set_idx | input | SET_W | Set addressed for both victim lookup and access update |
| touch_en | input | 1 | Access strobe for the way on touch_way |
| touch_way | input | 3 | Way that was accessed |
| valid_mask | input | 8 | Valid bit per way of the addressed set |
| victim_way | output | 3 | Way chosen for replacement |
| victim_invalid | output | 1 | High when the chosen way was empty |

## Verification
The assertions check on every cycle that an incomplete valid mask yields its lowest empty way with the flag set, and that a full mask clears the flag. They also check that a just-accessed way is never named victim in the following cycle, that idle cycles leave all state untouched, and that a clear leaves way 0 as the full-set victim. The exact tree walk for each bit pattern, the per-way update patterns and the isolation between sets are only visible through the bench. It drives long access sequences across many sets and compares every victim with an independent path-arithmetic model, then sweeps all sets to confirm untouched ones. The clear-beats-access ordering and the old-tree view in the strobe cycle are also scenario checks.

// File: rtl/plru8_pkg.sv
package plru8_pkg;
  localparam int WAYS  = 8;
  localparam int WAY_W = 3;
  localparam int NODES = WAYS - 1;

  typedef logic [WAY_W-1:0] way_t;
  typedef logic [NODES-1:0] tree_t;

  // Nodes rewritten by an access to each way (path from root to leaf).
  function automatic tree_t path_mask(way_t w);
    case (w)
      3'd0, 3'd1: return 7'b0001011;
      3'd2, 3'd3: return 7'b0010011;
      3'd4, 3'd5: return 7'b0100101;
      default:    return 7'b1000101;
    endcase
  endfunction

  // Values written on that path, steering the tree away from the way.
  function automatic tree_t path_value(way_t w);
    case (w)
      3'd0:    return 7'b0001011;
      3'd1:    return 7'b0000011;
      3'd2:    return 7'b0010001;
      3'd3:    return 7'b0000001;
      3'd4:    return 7'b0100100;
      3'd5:    return 7'b0000100;
      3'd6:    return 7'b1000000;
      default: return 7'b0000000;
    endcase
  endfunction
endpackage

// File: rtl/plru8_walk.sv
module plru8_walk
  import plru8_pkg::*;
(
  input  tree_t           node,
  input  logic [WAYS-1:0] valid_mask,
  output way_t            victim,
  output logic            hole
);
  way_t tree_pick;
  way_t empty_pick;
  logic empty_found;

  always_comb begin
    if (node[0]) begin
      if (node[2]) tree_pick = node[6] ? 3'd7 : 3'd6;
      else         tree_pick = node[5] ? 3'd5 : 3'd4;
    end else begin
      if (node[1]) tree_pick = node[4] ? 3'd3 : 3'd2;
      else         tree_pick = node[3] ? 3'd1 : 3'd0;
    end
  end

  always_comb begin
    empty_pick  = '0;
    empty_found = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_mask[i]) begin
        empty_pick  = way_t'(i);
        empty_found = 1'b1;
      end
    end
  end

  assign victim = empty_found ? empty_pick : tree_pick;
  assign hole   = empty_found;
endmodule

// File: rtl/plru8_next.sv
module plru8_next
  import plru8_pkg::*;
(
  input  tree_t cur,
  input  way_t  way,
  output tree_t nxt
);
  tree_t keep;
  assign keep = ~path_mask(way);
  assign nxt  = (cur & keep) | path_value(way);
endmodule

// File: rtl/plru8_bank.sv
module plru8_bank
  import plru8_pkg::*;
#(
  parameter  int SETS  = 128,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                 clk,
  input  logic                 wipe,
  input  logic                 wr_en,
  input  logic [SET_W-1:0]     wr_set,
  input  tree_t                wr_data,
  input  logic [SET_W-1:0]     rd_set,
  output tree_t                rd_data,
  output tree_t [SETS-1:0]     all_q
);
  tree_t [SETS-1:0] rows_q;

  for (genvar g = 0; g < SETS; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (wipe)
        rows_q[g] <= '0;
      else if (wr_en && (wr_set == SET_W'(g)))
        rows_q[g] <= wr_data;
    end
  end

  assign rd_data = rows_q[rd_set];
  assign all_q   = rows_q;
endmodule

// File: rtl/plru8_tree.sv
module plru8_tree
  import plru8_pkg::*;
#(
  parameter  int SETS  = 128,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic [SET_W-1:0] set_idx,
  input  logic             touch_en,
  input  logic [2:0]       touch_way,
  input  logic [7:0]       valid_mask,
  output logic [2:0]       victim_way,
  output logic             victim_invalid
);
  tree_t            cur_tree;
  tree_t            new_tree;
  tree_t [SETS-1:0] state_q;
  logic             wipe;

  assign wipe = rst | clr_all;

  plru8_bank #(.SETS(SETS)) u_bank (
    .clk     (clk),
    .wipe    (wipe),
    .wr_en   (touch_en),
    .wr_set  (set_idx),
    .wr_data (new_tree),
    .rd_set  (set_idx),
    .rd_data (cur_tree),
    .all_q   (state_q)
  );

  plru8_next u_next (
    .cur (cur_tree),
    .way (touch_way),
    .nxt (new_tree)
  );

  plru8_walk u_walk (
    .node       (cur_tree),
    .valid_mask (valid_mask),
    .victim     (victim_way),
    .hole       (victim_invalid)
  );
endmodule

// File: rtl/plru8_tree_chk.sv
module plru8_tree_chk
  import plru8_pkg::*;
#(
  parameter  int SETS  = 128,
  localparam int SET_W = $clog2(SETS)
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_all,
  input logic [SET_W-1:0] set_idx,
  input logic             touch_en,
  input logic [2:0]       touch_way,
  input logic [7:0]       valid_mask,
  input logic [2:0]       victim_way,
  input logic             victim_invalid,
  input tree_t [SETS-1:0] state_q
);
  logic [7:0] below;
  always_comb below = 8'((9'd1 << victim_way) - 9'd1);

  a_r2_lowest_empty: assert property (@(posedge clk) disable iff (rst)
    (valid_mask != 8'hFF) |-> (victim_invalid && !valid_mask[victim_way]
                               && ((valid_mask & below) == below)));

  a_r3_full_no_flag: assert property (@(posedge clk) disable iff (rst)
    (valid_mask == 8'hFF) |-> !victim_invalid);

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!touch_en && !clr_all) |=> (state_q == $past(state_q)));

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (valid_mask != 8'hFF || victim_way == 3'd0));

  a_r8_not_recent: assert property (@(posedge clk) disable iff (rst)
    (touch_en && !clr_all) |=> (set_idx != $past(set_idx) || valid_mask != 8'hFF
                                || victim_way != $past(touch_way)));
endmodule

bind plru8_tree plru8_tree_chk #(.SETS(SETS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .clr_all        (clr_all),
  .set_idx        (set_idx),
  .touch_en       (touch_en),
  .touch_way      (touch_way),
  .valid_mask     (valid_mask),
  .victim_way     (victim_way),
  .victim_invalid (victim_invalid),
  .state_q        (state_q)
);

// File: tb/plru8_tree_test.sv
module plru8_tree_test;
  localparam int SETS = 128;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr_all = 1'b0;
  logic [6:0] set_idx = '0;
  logic       touch_en = 1'b0;
  logic [2:0] touch_way = '0;
  logic [7:0] valid_mask = 8'hFF;
  logic [2:0] victim_way;
  logic       victim_invalid;

  logic [6:0] model [SETS];
  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  plru8_tree #(.SETS(SETS)) uut (
    .clk(clk), .rst(rst), .clr_all(clr_all), .set_idx(set_idx),
    .touch_en(touch_en), .touch_way(touch_way), .valid_mask(valid_mask),
    .victim_way(victim_way), .victim_invalid(victim_invalid)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Path arithmetic: root, then node 1+half, then node 3+2*half+pair.
  function automatic int walk(logic [6:0] b);
    int h = int'(b[0]);
    int g = int'(b[1 + h]);
    int l = int'(b[3 + 2 * h + g]);
    return 4 * h + 2 * g + l;
  endfunction

  function automatic logic [6:0] upd(logic [6:0] b, int w);
    logic [6:0] r = b;
    int h = (w >> 2) & 1;
    int g = (w >> 1) & 1;
    r[0]             = (h == 0);
    r[1 + h]         = (g == 0);
    r[3 + 2 * h + g] = ((w & 1) == 0);
    return r;
  endfunction

  task automatic step(int s, int w, bit en, logic [7:0] vm, bit clr, string tag);
    int ev = -1;
    @(negedge clk);
    set_idx = 7'(s); touch_way = 3'(w); touch_en = en; valid_mask = vm; clr_all = clr;
    #1;
    for (int i = 7; i >= 0; i--) if (!vm[i]) ev = i;
    if (ev >= 0) begin
      chk(tag, int'(victim_way), ev);
      chk(tag, int'(victim_invalid), 1);
    end else begin
      chk(tag, int'(victim_way), walk(model[s]));
      chk(tag, int'(victim_invalid), 0);
    end
    @(posedge clk);
    if (clr) begin
      for (int k = 0; k < SETS; k++) model[k] = '0;
    end else if (en) model[s] = upd(model[s], w);
    #1;
    touch_en = 1'b0; clr_all = 1'b0;
  endtask

  task automatic sweep(string tag);
    for (int s = 0; s < SETS; s++) step(s, 0, 1'b0, 8'hFF, 1'b0, tag);
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < SETS; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    sweep("R1");

    for (int m = 0; m < 256; m++)
      step(5, 0, 1'b0, 8'(m), 1'b0, (m == 255) ? "R3" : "R2");

    for (int w = 0; w < 8; w++) begin
      step(3, w, 1'b1, 8'hFF, 1'b0, "R4");
      chk("R8", int'(victim_way != 3'(w)), 1);
    end

    step(9, 0, 1'b1, 8'hFF, 1'b0, "R6");
    chk("R6", int'(victim_way), 4);

    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(int'(lfsr[6:0]), int'(lfsr[9:7]), lfsr[10] | lfsr[11],
           lfsr[12] ? 8'hFF : {lfsr[15:13], 5'h1F}, 1'b0, "R4");
    end

    sweep("R5");

    for (int w = 0; w < 8; w++) step(20 + w, w, 1'b1, 8'hFF, 1'b0, "R4");
    step(7, 3, 1'b1, 8'hFF, 1'b1, "R7");
    sweep("R7");

    for (int w = 0; w < 8; w++) step(40 + 2 * w, 7 - w, 1'b1, 8'hFF, 1'b0, "R4");
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    for (int k = 0; k < SETS; k++) model[k] = '0;
    @(negedge clk); rst = 1'b0;
    sweep("R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule